// File: doc/BRIEF.md
# Boundary Scan Register with Output-Enable Cell

This block is the boundary data register of a test access port. It is a serial chain of scan cells between the test data input and the test data output. Each cell has two stages: a capture/shift flop that takes part in the serial path, and an update latch that holds a parallel value. A TAP controller drives it with per-cycle strobes for capture, shift and update, with a select that says this register is the active data register, and with a mode flag for external test.

On capture, the shift stages take a snapshot of the device pin values. On shift, the chain moves one place toward the output while a new bit enters at the far end, so captured data leaves as preload data arrives. On update, the shift stages are copied into the latches. Under external test, the latches for the output bus drive the pads. One dedicated cell, the output-enable cell, gates the pad drivers. That cell is preset high at reset and whenever the controller reports its test-logic-reset state. Outside external test, the functional data and enable pass straight through to the pads.

Top module: `bsr_chain`

## Requirements
- R1: During and right after `trst_n` low, every shift stage is 0, so `tdo_o` is 0. Every update latch is 0 except the output-enable latch (cell `OE_BIT`, 47 by default), which is 1.
- R2: When `sel_i` and `capture_i` are high at a rising edge, every shift stage k loads `cap_i[k]`. Capture takes priority over shift in the same cycle.
- R3: When `sel_i` and `shift_i` are high without `capture_i`, each stage k takes the value of stage k+1, stage `CELLS-1` takes `tdi_i`, and `tdo_o` shows stage 0. A bit shifted in first ends up in cell 0 after `CELLS` shifts.
- R4: When `sel_i` and `update_i` are high at a rising edge, every latch k loads the pre-edge value of shift stage k.
- R5: Capture and shift never change an update latch. Under external test, `pad_q_o` and `pad_oe_o` stay steady while data streams through the chain.
- R6: With `extest_i` high, `pad_q_o[j]` equals latch `Q_LSB+j`.
- R7: With `extest_i` high, `pad_oe_o` equals the output-enable latch: 1 lets the bus drive, 0 puts it in high impedance.
- R8: A rising edge with `tlr_i` high sets the output-enable latch to 1, even against a simultaneous update. All other latches keep their values.
- R9: With `extest_i` low, `pad_q_o` equals `func_q_i` and `pad_oe_o` equals `func_oe_i`.
- R10: With `sel_i` low, the capture, shift and update strobes have no effect on the shift stages or the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr_i | input | 1 | Controller is in test-logic-reset |
| sel_i | input | 1 | Boundary register is the selected data register |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| extest_i | input | 1 | External test mode active |
| tdi_i | input | 1 | Serial data in (enters cell CELLS-1) |
| cap_i | input | CELLS | Pin snapshot, one bit per cell |
| func_q_i | input | QW | Functional output data |
| func_oe_i | input | 1 | Functional output enable |
| tdo_o | output | 1 | Serial data out (cell 0) |
| pad_q_o | output | QW | Data to output pads |
| pad_oe_o | output | 1 | Output pad driver enable |

## Verification
A corrupted shift stage shows up at `tdo_o` after as many shifts as it sits from cell 0, up to `CELLS` cycles later. A corrupted latch under external test shows up on `pad_q_o` or `pad_oe_o` in the very cycle it goes wrong. The bench therefore runs complete chain traversals with external test held on, so both paths are exposed every cycle. A wrong preset or a wrong test-logic-reset response of the enable cell changes `pad_oe_o` on the first cycle after reset or after the `tlr_i` pulse.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef struct packed {
      logic capture;
      logic shift;
      logic update;
      logic tlr;
   } bsr_ctl_t;

   localparam int unsigned BSR_CELLS_DEF = 107;
   localparam int unsigned BSR_OE_DEF    = 47;
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
   import bsr_pkg::*;
#(
   parameter bit PRESET_HI = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bsr_ctl_t ctl,
   input  logic     cap_d,
   input  logic     si,
   output logic     so,
   output logic     uq
);
   // capture/shift stage: capture wins over shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           so <= 1'b0;
      else if (ctl.capture) so <= cap_d;
      else if (ctl.shift)   so <= si;
   end

   generate
      if (PRESET_HI) begin : g_oe_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          uq <= 1'b1;
            else if (ctl.tlr)    uq <= 1'b1;
            else if (ctl.update) uq <= so;
         end
      end else begin : g_data_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          uq <= 1'b0;
            else if (ctl.update) uq <= so;
         end
      end
   endgenerate
endmodule

// File: rtl/bsr_padmux.sv
module bsr_padmux #(
   parameter int unsigned QW = 36
) (
   input  logic          extest,
   input  logic [QW-1:0] lat_q,
   input  logic          lat_oe,
   input  logic [QW-1:0] func_q,
   input  logic          func_oe,
   output logic [QW-1:0] pad_q,
   output logic          pad_oe
);
   always_comb begin
      if (extest) begin
         pad_q  = lat_q;
         pad_oe = lat_oe;
      end else begin
         pad_q  = func_q;
         pad_oe = func_oe;
      end
   end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int unsigned CELLS  = BSR_CELLS_DEF,
   parameter int unsigned OE_BIT = BSR_OE_DEF,
   parameter int unsigned Q_LSB  = 0,
   parameter int unsigned QW     = 36
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tlr_i,
   input  logic             sel_i,
   input  logic             capture_i,
   input  logic             shift_i,
   input  logic             update_i,
   input  logic             extest_i,
   input  logic             tdi_i,
   input  logic [CELLS-1:0] cap_i,
   input  logic [QW-1:0]    func_q_i,
   input  logic             func_oe_i,
   output logic             tdo_o,
   output logic [QW-1:0]    pad_q_o,
   output logic             pad_oe_o
);
   localparam int unsigned Q_MSB = Q_LSB + QW - 1;

   generate
      if (CELLS < 2) begin : g_bad_len
         $error("bsr_chain: CELLS must be at least 2");
      end
      if (OE_BIT >= CELLS) begin : g_bad_oe
         $error("bsr_chain: OE_BIT outside the chain");
      end
      if (Q_MSB >= CELLS) begin : g_bad_q
         $error("bsr_chain: output field outside the chain");
      end
      if (OE_BIT >= Q_LSB && OE_BIT <= Q_MSB) begin : g_bad_overlap
         $error("bsr_chain: OE_BIT overlaps the output field");
      end
   endgenerate

   bsr_ctl_t         ctl;
   logic [CELLS-1:0] sh_q;
   logic [CELLS-1:0] up_q;
   logic [CELLS-1:0] ser_in;

   always_comb begin
      ctl.capture = sel_i & capture_i;
      ctl.shift   = sel_i & shift_i;
      ctl.update  = sel_i & update_i;
      ctl.tlr     = tlr_i;
   end

   assign ser_in = {tdi_i, sh_q[CELLS-1:1]};

   for (genvar k = 0; k < CELLS; k++) begin : g_cell
      bsr_cell #(
         .PRESET_HI(k == OE_BIT)
      ) u_cell (
         .clk   (tck),
         .rst_n (trst_n),
         .ctl   (ctl),
         .cap_d (cap_i[k]),
         .si    (ser_in[k]),
         .so    (sh_q[k]),
         .uq    (up_q[k])
      );
   end

   assign tdo_o = sh_q[0];

   bsr_padmux #(
      .QW(QW)
   ) u_padmux (
      .extest  (extest_i),
      .lat_q   (up_q[Q_MSB:Q_LSB]),
      .lat_oe  (up_q[OE_BIT]),
      .func_q  (func_q_i),
      .func_oe (func_oe_i),
      .pad_q   (pad_q_o),
      .pad_oe  (pad_oe_o)
   );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
   parameter int unsigned CELLS  = 107,
   parameter int unsigned OE_BIT = 47,
   parameter int unsigned QW     = 36
) (
   input logic             tck,
   input logic             trst_n,
   input logic             tlr_i,
   input logic             sel_i,
   input logic             capture_i,
   input logic             shift_i,
   input logic             update_i,
   input logic             extest_i,
   input logic             cap0,
   input logic             tdo_o,
   input logic [QW-1:0]    pad_q_o,
   input logic             pad_oe_o,
   input logic [CELLS-1:0] sh_q,
   input logic [CELLS-1:0] up_q
);
   assert_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (sel_i && capture_i) |=> (tdo_o == $past(cap0)));

   assert_shift_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (sel_i && shift_i && !capture_i) |=> (tdo_o == $past(sh_q[1])));

   assert_update_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (sel_i && update_i && !tlr_i) |=> (up_q == $past(sh_q)));

   assert_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (extest_i && !(sel_i && update_i) && !tlr_i) |=>
         (!extest_i || ($stable(pad_q_o) && $stable(pad_oe_o))));

   assert_tlr_oe_R8: assert property (@(posedge tck) disable iff (!trst_n)
      tlr_i |=> up_q[OE_BIT]);

   assert_idle_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (!sel_i && !tlr_i) |=> ($stable(sh_q) && $stable(up_q) && $stable(tdo_o)));
endmodule

bind bsr_chain bsr_chain_chk #(
   .CELLS  (CELLS),
   .OE_BIT (OE_BIT),
   .QW     (QW)
) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tlr_i     (tlr_i),
   .sel_i     (sel_i),
   .capture_i (capture_i),
   .shift_i   (shift_i),
   .update_i  (update_i),
   .extest_i  (extest_i),
   .cap0      (cap_i[0]),
   .tdo_o     (tdo_o),
   .pad_q_o   (pad_q_o),
   .pad_oe_o  (pad_oe_o),
   .sh_q      (sh_q),
   .up_q      (up_q)
);

// File: tb/tb_bsr_chain.sv
`timescale 1ns/1ps
module tb_bsr_chain;
   localparam int CELLS = 107;
   localparam int OEB   = 47;
   localparam int QL    = 0;
   localparam int QW    = 36;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tlr = 0, sel = 0, cap = 0, shf = 0, upd = 0, ext = 0, tdi = 0;
   logic [CELLS-1:0] capv = '0;
   logic [QW-1:0] fq = '0;
   logic foe = 1'b0;
   logic tdo;
   logic [QW-1:0] pq;
   logic poe;

   always #5 tck = ~tck;

   bsr_chain dut (
      .tck(tck), .trst_n(trst_n), .tlr_i(tlr), .sel_i(sel),
      .capture_i(cap), .shift_i(shf), .update_i(upd), .extest_i(ext),
      .tdi_i(tdi), .cap_i(capv), .func_q_i(fq), .func_oe_i(foe),
      .tdo_o(tdo), .pad_q_o(pq), .pad_oe_o(poe));

   int total = 0;
   int fails = 0;
   string cur_req = "R1";

   // behavioural reference: a queue for the serial path, a bit array for latches
   bit sh[$];
   bit [CELLS-1:0] m_up;

   always @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh.delete();
         for (int k = 0; k < CELLS; k++) sh.push_back(1'b0);
         m_up = '0;
         m_up[OEB] = 1'b1;
      end else begin
         if (sel && upd)
            for (int k = 0; k < CELLS; k++) m_up[k] = sh[k];
         if (tlr) m_up[OEB] = 1'b1;
         if (sel && cap) begin
            for (int k = 0; k < CELLS; k++) sh[k] = capv[k];
         end else if (sel && shf) begin
            void'(sh.pop_front());
            sh.push_back(tdi);
         end
      end
   end

   task automatic compare(string req);
      logic [QW-1:0] eq;
      logic eoe;
      for (int j = 0; j < QW; j++) eq[j] = ext ? m_up[QL+j] : fq[j];
      eoe = ext ? m_up[OEB] : foe;
      total++;
      if (tdo !== sh[0] || pq !== eq || poe !== eoe) begin
         fails++;
         $display("FAIL %s: tdo=%b pad_q=%h pad_oe=%b expected tdo=%b pad_q=%h pad_oe=%b",
                  req, tdo, pq, poe, sh[0], eq, eoe);
      end
   endtask

   bit running = 0;
   always @(negedge tck) if (running && trst_n) compare(cur_req);

   task automatic tick();
      @(posedge tck); #2;
   endtask

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      @(negedge tck); #1;
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_in(logic [CELLS-1:0] v);
      sel = 1; shf = 1;
      for (int k = 0; k < CELLS; k++) begin tdi = v[k]; tick(); end
      shf = 0; tdi = 0;
   endtask

   task automatic pulse_update();
      sel = 1; upd = 1; tick(); upd = 0;
   endtask

   function automatic logic [CELLS-1:0] rnd_vec();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   bit done = 0;
   initial begin
      #2_000_000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [CELLS-1:0] v;
      logic [QW-1:0] saved;
      #1;
      ext = 1;
      repeat (2) tick();
      // R1: reset state seen at the ports
      chk("R1", {63'd0, tdo}, 64'd0);
      chk("R1", {63'd0, poe}, 64'd1);
      chk("R1", {28'd0, pq}, 64'd0);
      trst_n = 1; running = 1;
      tick();

      // R2: capture then R3: shift a full traversal with random data in
      cur_req = "R2";
      capv = rnd_vec();
      sel = 1; cap = 1; shf = 1; tick(); cap = 0; shf = 0;
      chk("R2", {63'd0, tdo}, {63'd0, capv[0]});
      cur_req = "R3";
      v = rnd_vec();
      v[OEB] = 1'b1;
      shift_in(v);
      chk("R3", {63'd0, tdo}, {63'd0, v[0]});

      // R4/R6: update and drive pads under extest
      cur_req = "R4";
      pulse_update();
      chk("R6", {28'd0, pq}, {28'd0, v[QL +: QW]});
      chk("R7", {63'd0, poe}, 64'd1);

      // R5: stream new data, latches hold
      cur_req = "R5";
      saved = pq;
      shift_in(rnd_vec());
      chk("R5", {28'd0, pq}, {28'd0, saved});

      // R7: enable cell low -> high impedance
      cur_req = "R7";
      v = rnd_vec(); v[OEB] = 1'b0;
      shift_in(v); pulse_update();
      chk("R7", {63'd0, poe}, 64'd0);
      chk("R6", {28'd0, pq}, {28'd0, v[QL +: QW]});

      // R8: test-logic-reset presets the enable, others unchanged
      cur_req = "R8";
      sel = 0; tlr = 1; tick(); tlr = 0;
      chk("R8", {63'd0, poe}, 64'd1);
      chk("R8", {28'd0, pq}, {28'd0, v[QL +: QW]});
      // tlr beats a simultaneous update with a zero in the enable cell
      v = rnd_vec(); v[OEB] = 1'b0;
      shift_in(v);
      sel = 1; upd = 1; tlr = 1; tick(); upd = 0; tlr = 0;
      chk("R8", {63'd0, poe}, 64'd1);
      chk("R4", {28'd0, pq}, {28'd0, v[QL +: QW]});

      // R10: strobes without select do nothing
      cur_req = "R10";
      saved = pq;
      sel = 0; cap = 1; capv = rnd_vec(); tdi = 1;
      tick(); cap = 0; shf = 1; tick(); shf = 0; upd = 1; tick(); upd = 0;
      chk("R10", {63'd0, tdo}, {63'd0, v[0]});
      chk("R10", {28'd0, pq}, {28'd0, saved});

      // R9: passthrough when extest is off
      cur_req = "R9";
      ext = 0;
      for (int n = 0; n < 8; n++) begin
         fq = {$urandom, $urandom}; foe = n[0];
         tick();
      end
      chk("R9", {28'd0, pq}, {28'd0, fq});
      chk("R9", {63'd0, poe}, {63'd0, foe});

      // R3: walking single one through the chain, extest off
      cur_req = "R3";
      v = '0; v[CELLS-1] = 1'b1;
      shift_in(v);
      chk("R3", {63'd0, tdo}, 64'd0);
      sel = 1; shf = 1; tdi = 0;
      repeat (CELLS - 1) tick();
      shf = 0;
      chk("R3", {63'd0, tdo}, 64'd1);

      repeat (2) tick();
      running = 0; done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule